// File: doc/BRIEF.md
# Boot-Time SPI Flash Word Reader

This block is the serial-flash side of a boot copier. Once the system reset is released it takes the attached SPI flash to a known state. It waits out a recovery time, then polls the device's status until the device is no longer busy. Next it issues the software-reset command sequence chosen by a parameter, and waits the recovery time again. After that it fetches a fixed number of 32-bit words, starting at a fixed flash address.

Every word is fetched in its own chip-select transaction. That transaction carries a read command, the word's address, and 32 data bits. The assembled word appears on a parallel output together with a single-cycle valid strobe. A single-cycle completion strobe follows the last word, and the block then stays idle until the next reset. The serial clock is the system clock divided by an even ratio. The serial interface uses mode 0: the clock idles low, data is sampled on the rising edge and shifted on the falling edge.

Top module: `flash_boot_reader`

## Requirements
- R1: The serial clock idles low whenever chip select is high. Its period is `CLK_DIV` system clocks, with equal high and low halves. The MOSI line changes only while the serial clock is low, and the bit order is most significant bit first.
- R2: While reset is asserted, chip select is high, the serial clock is low and both strobes are low. After reset is released, chip select stays high for at least `RECOVER_CYCLES` clocks before the first transaction.
- R3: Busy polling uses a 16-bit transaction: a command byte followed by one status byte. With `STATUS_KIND`=0 the command is 05h and status bit 0 high means busy. With `STATUS_KIND`=1 the command is D7h and status bit 7 low means busy. The poll is repeated until the device reports ready.
- R4: The software reset depends on `RST_KIND`. Kind 0 sends no command. Kind 1 sends 66h and then 99h, each as a separate 8-bit transaction. Kind 2 sends one 32-bit transaction F0h,00h,00h,00h. Kind 3 sends one 8-bit transaction F0h.
- R5: After the reset step, chip select stays high for at least `RECOVER_CYCLES` clocks before the first read.
- R6: When `WIDE_ADDR`=0, each read transaction is 64 bits long: command 03h, then a 24-bit address, then 32 data bits. When `WIDE_ADDR`=1 it is 72 bits long: command 13h, then a 32-bit address, then 32 data bits. Word n is read from `FLASH_BASE` + 4n.
- R7: Between any two consecutive transactions, chip select is high for at least `GAP_CYCLES` clocks.
- R8: Each word is presented on `word_data` with `word_valid` high for one cycle. The first data bit received becomes bit 31, so the first byte occupies bits 31:24.
- R9: Exactly `WORD_COUNT` words are presented, in ascending address order. `words_done` pulses once, in the cycle after the last `word_valid`. No further transaction follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| spi_sck | output | 1 | Serial clock to the flash |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low flash chip select |
| word_data | output | 32 | Most recently fetched word |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| words_done | output | 1 | One-cycle strobe after the final word |

## Verification
The embedded assertions check a few properties on every cycle. The serial clock stays low while chip select is high, and MOSI holds steady through each high phase of the clock. No transaction is active during a recovery or deselect wait. The word and completion strobes never coincide, and completion always follows a word strobe. Everything else can only be shown by the bench scenarios, which run four parameter sets against a behavioural flash model. These cover the order and content of command bytes, the status polarity and repeat count, the address sequence, data byte placement, and the measured gap and recovery times.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam int FRAME_W = 72;

  localparam logic [7:0] OP_STAT_A  = 8'h05;
  localparam logic [7:0] OP_STAT_B  = 8'hD7;
  localparam logic [7:0] OP_RST_EN  = 8'h66;
  localparam logic [7:0] OP_RST_GO  = 8'h99;
  localparam logic [7:0] OP_RST_ALT = 8'hF0;
  localparam logic [7:0] OP_READ3   = 8'h03;
  localparam logic [7:0] OP_READ4   = 8'h13;

  typedef enum logic [3:0] {
    S_REC1, S_STAT, S_GAP_STAT, S_RST1, S_GAP_RST, S_RST2,
    S_REC2, S_READ, S_GAP_READ, S_FIN, S_IDLE
  } seq_state_t;
endpackage

// File: rtl/fbr_spi_shifter.sv
module fbr_spi_shifter
  import fbr_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic [6:0]         nbits,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic               cs_n,
  output logic [31:0]        rx_word,
  output logic               finish,
  output logic               busy
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HW   = $clog2(HALF) + 1;

  logic [HW-1:0]      hcnt;
  logic [6:0]         left;
  logic [FRAME_W-1:0] tx;
  logic               phase_end;

  assign phase_end = busy && (hcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      hcnt    <= '0;
      left    <= '0;
      tx      <= '0;
      rx_word <= '0;
      finish  <= 1'b0;
    end else begin
      finish <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;
        sck  <= 1'b0;
        tx   <= frame;
        left <= nbits;
        hcnt <= HW'(HALF - 1);
      end else if (busy && !phase_end) begin
        hcnt <= hcnt - 1'b1;
      end else if (phase_end) begin
        hcnt <= HW'(HALF - 1);
        if (!sck) begin
          sck     <= 1'b1;
          rx_word <= {rx_word[30:0], miso};
        end else begin
          sck  <= 1'b0;
          tx   <= {tx[FRAME_W-2:0], 1'b0};
          left <= left - 1'b1;
          if (left == 7'd1) begin
            busy   <= 1'b0;
            finish <= 1'b1;
          end
        end
      end
    end
  end

  assign mosi = tx[FRAME_W-1];
  assign cs_n = ~busy;

  // R1: clock parks low while deselected
  a_r1_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R1: data line is held through every high phase of the clock
  a_r1_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

// File: rtl/fbr_sequencer.sv
module fbr_sequencer
  import fbr_pkg::*;
#(
  parameter int          RST_KIND       = 1,
  parameter int          STATUS_KIND    = 0,
  parameter int          WIDE_ADDR      = 0,
  parameter logic [31:0] FLASH_BASE     = 32'h0,
  parameter int          WORD_COUNT     = 2048,
  parameter int          RECOVER_CYCLES = 8,
  parameter int          GAP_CYCLES     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eng_busy,
  input  logic               eng_done,
  input  logic [31:0]        eng_rx,
  output logic               eng_start,
  output logic [FRAME_W-1:0] eng_frame,
  output logic [6:0]         eng_nbits,
  output logic [31:0]        word_data,
  output logic               word_valid,
  output logic               words_done
);
  localparam int          CNT_MAX = (RECOVER_CYCLES > GAP_CYCLES) ? RECOVER_CYCLES : GAP_CYCLES;
  localparam int          CW      = $clog2(CNT_MAX + 1);
  localparam int          WCW     = $clog2(WORD_COUNT + 1);
  localparam logic [7:0]  STAT_OP = (STATUS_KIND != 0) ? OP_STAT_B : OP_STAT_A;
  localparam int          ZW      = FRAME_W - 8;

  seq_state_t      st, nxt;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [WCW-1:0]  words_q;
  logic [31:0]     addr_q;
  logic            dev_busy_q;
  logic            last_word;

  assign last_word = (words_q == WCW'(WORD_COUNT - 1));

  always_comb begin
    nxt = st;
    case (st)
      S_REC1:     if (cnt_q == '0) nxt = S_STAT;
      S_STAT:     if (eng_done) nxt = S_GAP_STAT;
      S_GAP_STAT: if (cnt_q == '0)
                    nxt = dev_busy_q ? S_STAT : ((RST_KIND == 0) ? S_REC2 : S_RST1);
      S_RST1:     if (eng_done) nxt = (RST_KIND == 1) ? S_GAP_RST : S_REC2;
      S_GAP_RST:  if (cnt_q == '0) nxt = S_RST2;
      S_RST2:     if (eng_done) nxt = S_REC2;
      S_REC2:     if (cnt_q == '0) nxt = S_READ;
      S_READ:     if (eng_done) nxt = last_word ? S_FIN : S_GAP_READ;
      S_GAP_READ: if (cnt_q == '0) nxt = S_READ;
      S_FIN:      nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase

    eng_start = (nxt != st) && (nxt inside {S_STAT, S_RST1, S_RST2, S_READ});
    eng_frame = '0;
    eng_nbits = '0;
    case (nxt)
      S_STAT: begin
        eng_frame = {STAT_OP, {ZW{1'b0}}};
        eng_nbits = 7'd16;
      end
      S_RST1: begin
        eng_frame = {(RST_KIND == 1) ? OP_RST_EN : OP_RST_ALT, {ZW{1'b0}}};
        eng_nbits = (RST_KIND == 2) ? 7'd32 : 7'd8;
      end
      S_RST2: begin
        eng_frame = {OP_RST_GO, {ZW{1'b0}}};
        eng_nbits = 7'd8;
      end
      S_READ: begin
        if (WIDE_ADDR != 0) begin
          eng_frame = {OP_READ4, addr_q, 32'h0};
          eng_nbits = 7'd72;
        end else begin
          eng_frame = {OP_READ3, addr_q[23:0], 40'h0};
          eng_nbits = 7'd64;
        end
      end
      default: ;
    endcase

    if (nxt != st && (nxt inside {S_GAP_STAT, S_GAP_RST, S_GAP_READ}))
      cnt_d = CW'(GAP_CYCLES - 1);
    else if (nxt != st && nxt == S_REC2)
      cnt_d = CW'(RECOVER_CYCLES - 1);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
    else
      cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_REC1;
      cnt_q      <= CW'(RECOVER_CYCLES - 1);
      words_q    <= '0;
      addr_q     <= FLASH_BASE;
      dev_busy_q <= 1'b0;
      word_data  <= '0;
      word_valid <= 1'b0;
      words_done <= 1'b0;
    end else begin
      st         <= nxt;
      cnt_q      <= cnt_d;
      word_valid <= (st == S_READ) && eng_done;
      words_done <= (st == S_FIN);
      if (st == S_STAT && eng_done)
        dev_busy_q <= (STATUS_KIND != 0) ? ~eng_rx[7] : eng_rx[0];
      if (st == S_READ && eng_done) begin
        word_data <= eng_rx;
        addr_q    <= addr_q + 32'd4;
        if (!last_word) words_q <= words_q + 1'b1;
      end
    end
  end

  // R7: no transaction is active while a recovery or deselect wait runs
  a_r7_quiet_during_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (st inside {S_REC1, S_GAP_STAT, S_GAP_RST, S_REC2, S_GAP_READ, S_IDLE}) |-> !eng_busy);

  // R8: word and completion strobes are never raised together
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({word_valid, words_done}));

  // R9: completion comes directly after a word strobe
  a_r9_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    words_done |-> $past(word_valid));
endmodule

// File: rtl/flash_boot_reader.sv
module flash_boot_reader
  import fbr_pkg::*;
#(
  parameter int          CLK_DIV        = 4,
  parameter int          RST_KIND       = 1,
  parameter int          STATUS_KIND    = 0,
  parameter int          WIDE_ADDR      = 0,
  parameter logic [31:0] FLASH_BASE     = 32'h0,
  parameter int          WORD_COUNT     = 2048,
  parameter int          RECOVER_CYCLES = 8,
  parameter int          GAP_CYCLES     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n,
  output logic [31:0] word_data,
  output logic        word_valid,
  output logic        words_done
);
  logic               eng_start, eng_done, eng_busy;
  logic [FRAME_W-1:0] eng_frame;
  logic [6:0]         eng_nbits;
  logic [31:0]        eng_rx;

  fbr_sequencer #(
    .RST_KIND(RST_KIND), .STATUS_KIND(STATUS_KIND), .WIDE_ADDR(WIDE_ADDR),
    .FLASH_BASE(FLASH_BASE), .WORD_COUNT(WORD_COUNT),
    .RECOVER_CYCLES(RECOVER_CYCLES), .GAP_CYCLES(GAP_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .eng_done(eng_done),
    .eng_rx(eng_rx), .eng_start(eng_start), .eng_frame(eng_frame),
    .eng_nbits(eng_nbits), .word_data(word_data), .word_valid(word_valid),
    .words_done(words_done)
  );

  fbr_spi_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .frame(eng_frame),
    .nbits(eng_nbits), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
    .cs_n(spi_cs_n), .rx_word(eng_rx), .finish(eng_done), .busy(eng_busy)
  );
endmodule

// File: tb/test_flash_boot_reader.sv
module fbr_flash_model #(
  parameter int STATUS_KIND = 0
) (
  input  logic        sck,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  input  logic [31:0] salt,
  input  int          polls
);
  logic [7:0]  log_first [32];
  int          log_bits  [32];
  logic [71:0] log_sr    [32];
  int          n_log = 0;
  logic [71:0] sr = '0;
  logic [7:0]  cmd = '0;
  logic [7:0]  stat = '0;
  logic [31:0] addr = '0;
  logic [31:0] dw;
  int          nb = 0;
  int          polls_done = 0;
  logic        p_cs = 1'b1;
  logic        p_sck = 1'b0;
  logic        miso_q = 1'b0;
  logic [7:0]  stat_op;

  assign miso    = miso_q;
  assign stat_op = (STATUS_KIND != 0) ? 8'hD7 : 8'h05;

  function automatic logic [31:0] content(input logic [31:0] a, input logic [31:0] s);
    return (a * 32'h9E3779B1) ^ s ^ {a[15:0], a[31:16]};
  endfunction

  always @(sck or cs_n) begin
    if (cs_n === 1'b0 && p_cs === 1'b1) begin
      nb = 0; sr = '0; cmd = '0; miso_q = 1'b0;
    end else if (cs_n === 1'b1 && p_cs === 1'b0) begin
      if (n_log < 32) begin
        log_first[n_log] = cmd; log_bits[n_log] = nb; log_sr[n_log] = sr;
      end
      n_log++;
      if (cmd == stat_op) polls_done++;
    end else if (cs_n === 1'b0 && sck !== p_sck) begin
      if (sck === 1'b1) begin
        sr = {sr[70:0], mosi};
        nb++;
        if (nb == 8) begin
          cmd = sr[7:0];
          if (STATUS_KIND != 0) stat = (polls_done < polls) ? 8'h7F : 8'h81;
          else                  stat = (polls_done < polls) ? 8'h03 : 8'h82;
        end
        if (cmd == 8'h03 && nb == 32) addr = {8'h00, sr[23:0]};
        if (cmd == 8'h13 && nb == 40) addr = sr[31:0];
      end else begin
        dw = content(addr, salt);
        if (cmd == stat_op && nb >= 8 && nb < 16)        miso_q = stat[3'(15 - nb)];
        else if (cmd == 8'h03 && nb >= 32 && nb < 64)   miso_q = dw[5'(63 - nb)];
        else if (cmd == 8'h13 && nb >= 40 && nb < 72)   miso_q = dw[5'(71 - nb)];
        else                                             miso_q = 1'b0;
      end
    end
    p_cs  = cs_n;
    p_sck = sck;
  end
endmodule

module fbr_lane #(
  parameter int          CLK_DIV        = 4,
  parameter int          RST_KIND       = 1,
  parameter int          STATUS_KIND    = 0,
  parameter int          WIDE_ADDR      = 0,
  parameter logic [31:0] FLASH_BASE     = 32'h0,
  parameter int          WORD_COUNT     = 4,
  parameter int          RECOVER_CYCLES = 8,
  parameter int          GAP_CYCLES     = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        finish,
  input  logic [31:0] salt,
  input  int          polls,
  output int          n_chk,
  output int          n_bad,
  output logic        saw_done
);
  logic        sck, mosi, miso, cs_n, wvalid, wdone;
  logic [31:0] wdata;
  int   chk_cnt = 0, bad_cnt = 0;
  int   hi_run = 0, run = 0, ntx = 0, wi = 0;
  int   gap_log [32];
  logic p_cs = 1'b1, p_sck = 1'b0, p_valid = 1'b0;
  logic rst_seen = 1'b0, fin_done = 1'b0, done_q = 1'b0;

  assign n_chk    = chk_cnt;
  assign n_bad    = bad_cnt;
  assign saw_done = done_q;

  flash_boot_reader #(
    .CLK_DIV(CLK_DIV), .RST_KIND(RST_KIND), .STATUS_KIND(STATUS_KIND),
    .WIDE_ADDR(WIDE_ADDR), .FLASH_BASE(FLASH_BASE), .WORD_COUNT(WORD_COUNT),
    .RECOVER_CYCLES(RECOVER_CYCLES), .GAP_CYCLES(GAP_CYCLES)
  ) i_flash_boot_reader (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso),
    .spi_cs_n(cs_n), .word_data(wdata), .word_valid(wvalid), .words_done(wdone)
  );

  fbr_flash_model #(.STATUS_KIND(STATUS_KIND)) i_model (
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso), .salt(salt), .polls(polls)
  );

  function automatic logic [31:0] content(input logic [31:0] a, input logic [31:0] s);
    return (a * 32'h9E3779B1) ^ s ^ {a[15:0], a[31:16]};
  endfunction

  function automatic logic [31:0] word_addr(input int w);
    logic [31:0] a;
    a = FLASH_BASE + 32'(4 * w);
    if (WIDE_ADDR == 0) a = {8'h00, a[23:0]};
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    chk_cnt++;
    if (!ok) begin
      bad_cnt++;
      $display("FAIL %s (div %0d kind %0d): actual %0h expected %0h", req, CLK_DIV, RST_KIND, act, exp);
    end
  endtask

  task automatic final_checks();
    int k;
    int nrst;
    k    = 0;
    nrst = (RST_KIND == 0) ? 0 : ((RST_KIND == 1) ? 2 : 1);
    chk(i_model.n_log == polls + 1 + nrst + WORD_COUNT && ntx == i_model.n_log,
        "R9 transaction total", 72'(i_model.n_log), 72'(polls + 1 + nrst + WORD_COUNT));
    chk(done_q, "R9 completion seen", 72'(done_q), 72'd1);
    chk(gap_log[0] >= RECOVER_CYCLES, "R2 first recovery", 72'(gap_log[0]), 72'(RECOVER_CYCLES));
    for (int p = 0; p <= polls; p++) begin
      chk(i_model.log_first[k] == ((STATUS_KIND != 0) ? 8'hD7 : 8'h05) && i_model.log_bits[k] == 16,
          "R3 status poll", {i_model.log_first[k], 64'(i_model.log_bits[k])},
          {((STATUS_KIND != 0) ? 8'hD7 : 8'h05), 64'd16});
      k++;
    end
    if (RST_KIND == 1) begin
      chk(i_model.log_first[k] == 8'h66 && i_model.log_bits[k] == 8, "R4 reset enable",
          {i_model.log_first[k], 64'(i_model.log_bits[k])}, {8'h66, 64'd8});
      k++;
      chk(i_model.log_first[k] == 8'h99 && i_model.log_bits[k] == 8, "R4 reset go",
          {i_model.log_first[k], 64'(i_model.log_bits[k])}, {8'h99, 64'd8});
      k++;
    end else if (RST_KIND == 2) begin
      chk(i_model.log_sr[k][31:0] == 32'hF000_0000 && i_model.log_bits[k] == 32, "R4 long reset",
          {i_model.log_sr[k][31:0], 40'(i_model.log_bits[k])}, {32'hF000_0000, 40'd32});
      k++;
    end else if (RST_KIND == 3) begin
      chk(i_model.log_first[k] == 8'hF0 && i_model.log_bits[k] == 8, "R4 short reset",
          {i_model.log_first[k], 64'(i_model.log_bits[k])}, {8'hF0, 64'd8});
      k++;
    end
    chk(gap_log[k] >= RECOVER_CYCLES, "R5 recovery before read", 72'(gap_log[k]), 72'(RECOVER_CYCLES));
    for (int j = 1; j < ntx && j < 32; j++)
      chk(gap_log[j] >= GAP_CYCLES, "R7 deselect gap", 72'(gap_log[j]), 72'(GAP_CYCLES));
    for (int w = 0; w < WORD_COUNT; w++) begin
      logic [7:0]  c;
      logic [31:0] a;
      if (WIDE_ADDR != 0) begin c = i_model.log_sr[k][71:64]; a = i_model.log_sr[k][63:32]; end
      else begin c = i_model.log_sr[k][63:56]; a = {8'h00, i_model.log_sr[k][55:32]}; end
      chk(c == ((WIDE_ADDR != 0) ? 8'h13 : 8'h03) && a == word_addr(w) &&
          i_model.log_bits[k] == ((WIDE_ADDR != 0) ? 72 : 64),
          "R6 read frame", {c, a, 32'(i_model.log_bits[k])},
          {((WIDE_ADDR != 0) ? 8'h13 : 8'h03), word_addr(w), 32'((WIDE_ADDR != 0) ? 72 : 64)});
      k++;
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      if (!rst_seen) begin
        chk(cs_n && !sck && !wvalid && !wdone, "R2 reset state",
            72'({cs_n, sck, wvalid, wdone}), 72'b1000);
        rst_seen = 1'b1;
      end
      hi_run = 0; run = 0; ntx = 0; wi = 0;
      p_cs = 1'b1; p_sck = 1'b0; p_valid = 1'b0; done_q = 1'b0;
    end else begin
      if (cs_n) hi_run++;
      else if (p_cs) begin
        if (ntx < 32) gap_log[ntx] = hi_run;
        ntx++;
        hi_run = 0;
      end
      if (!cs_n || !p_cs) begin
        if (p_cs && !cs_n) run = 1;
        else if (sck != p_sck) begin
          chk(run == CLK_DIV / 2, "R1 serial clock half period", 72'(run), 72'(CLK_DIV / 2));
          run = 1;
        end else run++;
      end
      if (wvalid) begin
        chk(wdata == content(word_addr(wi), salt), "R8 word data",
            72'(wdata), 72'(content(word_addr(wi), salt)));
        chk(wi < WORD_COUNT, "R9 word count bound", 72'(wi), 72'(WORD_COUNT));
        wi++;
      end
      if (wdone) begin
        chk(p_valid && wi == WORD_COUNT && !done_q, "R9 completion after last word",
            {8'(p_valid), 64'(wi)}, {8'd1, 64'(WORD_COUNT)});
        done_q = 1'b1;
      end
      p_cs = cs_n; p_sck = sck; p_valid = wvalid;
      if (finish && !fin_done) begin
        fin_done = 1'b1;
        final_checks();
      end
    end
  end
endmodule

module test_flash_boot_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        finish = 1'b0;
  logic [31:0] salt [4];
  int          polls [4];
  int          c [4];
  int          b [4];
  logic        d [4];
  int          total_chk, total_bad;
  bit          timeout;

  always #2 clk = ~clk;

  fbr_lane #(.CLK_DIV(4), .RST_KIND(1), .STATUS_KIND(0), .WIDE_ADDR(0),
             .FLASH_BASE(32'h0012_3400), .WORD_COUNT(6), .RECOVER_CYCLES(8), .GAP_CYCLES(8))
    u_lane0 (.clk(clk), .rst_n(rst_n), .finish(finish), .salt(salt[0]), .polls(polls[0]),
             .n_chk(c[0]), .n_bad(b[0]), .saw_done(d[0]));
  fbr_lane #(.CLK_DIV(6), .RST_KIND(2), .STATUS_KIND(1), .WIDE_ADDR(1),
             .FLASH_BASE(32'h8100_0010), .WORD_COUNT(5), .RECOVER_CYCLES(5), .GAP_CYCLES(3))
    u_lane1 (.clk(clk), .rst_n(rst_n), .finish(finish), .salt(salt[1]), .polls(polls[1]),
             .n_chk(c[1]), .n_bad(b[1]), .saw_done(d[1]));
  fbr_lane #(.CLK_DIV(10), .RST_KIND(3), .STATUS_KIND(0), .WIDE_ADDR(0),
             .FLASH_BASE(32'h00FF_FFF0), .WORD_COUNT(3), .RECOVER_CYCLES(4), .GAP_CYCLES(1))
    u_lane2 (.clk(clk), .rst_n(rst_n), .finish(finish), .salt(salt[2]), .polls(polls[2]),
             .n_chk(c[2]), .n_bad(b[2]), .saw_done(d[2]));
  fbr_lane #(.CLK_DIV(4), .RST_KIND(0), .STATUS_KIND(1), .WIDE_ADDR(1),
             .FLASH_BASE(32'h0000_0000), .WORD_COUNT(1), .RECOVER_CYCLES(4), .GAP_CYCLES(2))
    u_lane3 (.clk(clk), .rst_n(rst_n), .finish(finish), .salt(salt[3]), .polls(polls[3]),
             .n_chk(c[3]), .n_bad(b[3]), .saw_done(d[3]));

  initial begin
    salt[0]  = $urandom(32'd2024);
    salt[1]  = $urandom;
    salt[2]  = $urandom;
    salt[3]  = $urandom;
    polls[0] = int'($urandom_range(3, 0));
    polls[1] = int'($urandom_range(3, 1));
    polls[2] = 2;
    polls[3] = 0;
    #1 rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 150000 && !(d[0] && d[1] && d[2] && d[3]); i++) @(negedge clk);
    timeout = !(d[0] && d[1] && d[2] && d[3]);
    repeat (300) @(negedge clk);
    finish = 1'b1;
    repeat (3) @(negedge clk);
    total_chk = c[0] + c[1] + c[2] + c[3] + 1;
    total_bad = b[0] + b[1] + b[2] + b[3];
    if (timeout) begin
      total_bad++;
      $display("FAIL R9 watchdog: actual %0d%0d%0d%0d expected 1111", d[0], d[1], d[2], d[3]);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", total_chk, total_bad);
    $finish;
  end
endmodule